// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves an address translation miss by reading a two-level page table out of memory. A control register holds the base of the top-level table. When a faulting virtual address arrives, the walker issues one 32-bit read for the directory entry and, if that entry is present, a second 32-bit read for the leaf entry. It then presents either a completed translation, ready for installation in a translation cache, or a page fault that names the level that failed.

The walker does not interpret what it fetches beyond the present and user bits. It does not check whether an entry points at a real table. A directory entry that points back at its own directory therefore resolves to the directory's own frame, and software can use this to map the tables into its address space. One walk runs at a time.

The FSM has seven states. IDLE waits for a start. READ_DIR issues the directory read. WAIT_DIR waits for its response. READ_TBL issues the leaf read. WAIT_TBL waits for its response. DONE presents the translation for one cycle. FAULT presents the fault for one cycle.

The transitions are as follows. IDLE moves to READ_DIR on start. READ_DIR always moves to WAIT_DIR. WAIT_DIR moves to READ_TBL on a response with the present bit set, and to FAULT on a response with it clear. READ_TBL always moves to WAIT_TBL. WAIT_TBL moves to DONE on a present response, and to FAULT otherwise. DONE and FAULT both return to IDLE.

Top module: `ptw_top`

## Requirements
- R1: After reset the walker is idle. busy, mem_req_valid, done_valid and fault_valid are all 0.
- R2: The first read address is the root base with bits 11:0 cleared, plus 4 times the directory index. The directory index is bits 31:22 of the virtual address.
- R3: The second read address is bits 31:12 of the directory entry, with 12 zero bits appended, plus 4 times the table index. The table index is bits 21:12 of the virtual address.
- R4: A walk whose two entries are both present raises done_valid for one cycle, with fault_valid held at 0. In that cycle done_pfn is bits 31:12 of the leaf entry, done_flags is bits 11:0 of the leaf entry, and done_vpn is bits 31:12 of the virtual address.
- R5: A directory entry with bit 0 (present) clear ends the walk after one read. fault_valid is raised with fault_level 0 and fault_va equal to the virtual address, and no translation is produced.
- R6: A leaf entry with bit 0 clear ends the walk after two reads. fault_valid is raised with fault_level 1 and fault_va equal to the virtual address.
- R7: done_user is the AND of bit 2 of the directory entry and bit 2 of the leaf entry.
- R8: A start while busy is 1 is ignored. The walk in progress keeps its address, and no extra read follows it.
- R9: A root write in the same cycle as an accepted start is used by that walk. A root write while a walk is in progress affects only later walks.
- R10: Self-reference is not detected. With root 0x12345000 and directory entry 1023 equal to 0x12345xxx (present), address 0xFFFFF000 resolves to frame 0x12345 after two reads, both to 0x12345FFC.
- R11: Each memory request is a one-cycle pulse. The walker then waits any number of cycles for mem_rsp_valid, and busy is 1 while a request is out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| root_wr | input | 1 | Write strobe for the root base register |
| root_wdata | input | 32 | New root base value |
| start | input | 1 | Begin a walk for va (taken only when idle) |
| va | input | 32 | Faulting virtual address |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | One-cycle read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 32 | Entry read from memory |
| done_valid | output | 1 | Translation completed (one cycle) |
| done_vpn | output | 20 | Virtual page number of the walk |
| done_pfn | output | 20 | Physical frame number from the leaf entry |
| done_flags | output | 12 | Flag bits of the leaf entry |
| done_user | output | 1 | AND of the user bits at both levels |
| fault_valid | output | 1 | Page fault (one cycle) |
| fault_level | output | 1 | 0 means the directory entry was absent, 1 means the leaf entry was absent |
| fault_va | output | 32 | Virtual address that faulted |

## Verification
Two functions of this block can fall in the same cycle: a root base write and the acceptance of a start. The bench provokes this on purpose by driving root_wr and start together at the first walk. It then checks that the first read address is built from the newly written base. The bench also drives a root write and a second start one cycle into a walk in progress. There the reads must still follow the old base and the first address, and no third read may follow once the walk ends.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_DIR,
        ST_WAIT_DIR,
        ST_READ_TBL,
        ST_WAIT_TBL,
        ST_DONE,
        ST_FAULT
    } walk_state_e;

endpackage

// File: rtl/ptw_root_reg.sv
module ptw_root_reg #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr) begin
            q <= wdata;
        end
    end

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int AW         = 32,
    parameter int OFF_BITS   = 12,
    parameter int DIR_BITS   = 10,
    parameter int ENTRY_LOG2 = 2
) (
    input  logic [AW-1:0]          root,
    input  logic [AW-1:0]          pde,
    input  logic [AW-1:OFF_BITS]   vpn,
    output logic [AW-1:0]          dir_addr,
    output logic [AW-1:0]          tbl_addr
);

    localparam int TBL_BITS = AW - OFF_BITS - DIR_BITS;
    localparam logic [AW-1:0] FRAME_MASK = {{(AW-OFF_BITS){1'b1}}, {OFF_BITS{1'b0}}};

    logic [DIR_BITS-1:0] dir_idx;
    logic [TBL_BITS-1:0] tbl_idx;

    assign dir_idx = vpn[AW-1 -: DIR_BITS];
    assign tbl_idx = vpn[OFF_BITS +: TBL_BITS];

    // Base of each table is frame-aligned; entries are 2**ENTRY_LOG2 bytes apart
    assign dir_addr = (root & FRAME_MASK) + (AW'(dir_idx) << ENTRY_LOG2);
    assign tbl_addr = (pde  & FRAME_MASK) + (AW'(tbl_idx) << ENTRY_LOG2);

endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
    import ptw_pkg::*;
#(
    parameter int AW          = 32,
    parameter int OFF_BITS    = 12,
    parameter int PRESENT_BIT = 0,
    parameter int USER_BIT    = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [AW-1:0]          va_in,
    input  logic [AW-1:0]          root_q,
    input  logic                   root_wr,
    input  logic [AW-1:0]          root_wdata,
    input  logic [AW-1:0]          dir_addr,
    input  logic [AW-1:0]          tbl_addr,
    input  logic                   rsp_valid,
    input  logic [AW-1:0]          rsp_data,
    output logic [AW-1:0]          cur_root,
    output logic [AW-1:0]          cur_pde,
    output logic [AW-1:OFF_BITS]   cur_vpn,
    output logic                   busy,
    output logic                   req_valid,
    output logic [AW-1:0]          req_addr,
    output logic                   done_valid,
    output logic [AW-OFF_BITS-1:0] done_vpn,
    output logic [AW-OFF_BITS-1:0] done_pfn,
    output logic [OFF_BITS-1:0]    done_flags,
    output logic                   done_user,
    output logic                   fault_valid,
    output logic                   fault_level,
    output logic [AW-1:0]          fault_va
);

    walk_state_e state, nxt;

    logic [AW-1:0] va_q;
    logic [AW-1:0] root_cap;
    logic [AW-1:0] pde_q;
    logic [AW-1:0] pte_q;
    logic          lvl_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (start) nxt = ST_READ_DIR;
            ST_READ_DIR: nxt = ST_WAIT_DIR;
            ST_WAIT_DIR: if (rsp_valid) nxt = rsp_data[PRESENT_BIT] ? ST_READ_TBL : ST_FAULT;
            ST_READ_TBL: nxt = ST_WAIT_TBL;
            ST_WAIT_TBL: if (rsp_valid) nxt = rsp_data[PRESENT_BIT] ? ST_DONE : ST_FAULT;
            ST_DONE:     nxt = ST_IDLE;
            ST_FAULT:    nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // Walk context capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q     <= '0;
            root_cap <= '0;
            pde_q    <= '0;
            pte_q    <= '0;
            lvl_q    <= 1'b0;
        end else begin
            if (state == ST_IDLE && start) begin
                va_q     <= va_in;
                // A write in the same cycle as the start takes effect for this walk
                root_cap <= root_wr ? root_wdata : root_q;
            end
            if (state == ST_WAIT_DIR && rsp_valid) begin
                pde_q <= rsp_data;
                if (!rsp_data[PRESENT_BIT]) lvl_q <= 1'b0;
            end
            if (state == ST_WAIT_TBL && rsp_valid) begin
                pte_q <= rsp_data;
                if (!rsp_data[PRESENT_BIT]) lvl_q <= 1'b1;
            end
        end
    end

    assign cur_root = root_cap;
    assign cur_pde  = pde_q;
    assign cur_vpn  = va_q[AW-1:OFF_BITS];

    // Output logic
    always_comb begin
        busy        = 1'b1;
        req_valid   = 1'b0;
        req_addr    = tbl_addr;
        done_valid  = 1'b0;
        fault_valid = 1'b0;
        unique case (state)
            ST_IDLE:     busy = 1'b0;
            ST_READ_DIR: begin
                req_valid = 1'b1;
                req_addr  = dir_addr;
            end
            ST_WAIT_DIR: req_addr = dir_addr;
            ST_READ_TBL: req_valid = 1'b1;
            ST_WAIT_TBL: ;
            ST_DONE:     done_valid = 1'b1;
            ST_FAULT:    fault_valid = 1'b1;
            default:     busy = 1'b0;
        endcase
    end

    assign done_vpn    = va_q[AW-1:OFF_BITS];
    assign done_pfn    = pte_q[AW-1:OFF_BITS];
    assign done_flags  = pte_q[OFF_BITS-1:0];
    assign done_user   = pde_q[USER_BIT] & pte_q[USER_BIT];
    assign fault_level = lvl_q;
    assign fault_va    = va_q;

endmodule

// File: rtl/ptw_top.sv
module ptw_top #(
    parameter int AW          = 32,
    parameter int OFF_BITS    = 12,
    parameter int DIR_BITS    = 10,
    parameter int ENTRY_LOG2  = 2,
    parameter int PRESENT_BIT = 0,
    parameter int USER_BIT    = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   root_wr,
    input  logic [AW-1:0]          root_wdata,
    input  logic                   start,
    input  logic [AW-1:0]          va,
    output logic                   busy,
    output logic                   mem_req_valid,
    output logic [AW-1:0]          mem_req_addr,
    input  logic                   mem_rsp_valid,
    input  logic [AW-1:0]          mem_rsp_data,
    output logic                   done_valid,
    output logic [AW-OFF_BITS-1:0] done_vpn,
    output logic [AW-OFF_BITS-1:0] done_pfn,
    output logic [OFF_BITS-1:0]    done_flags,
    output logic                   done_user,
    output logic                   fault_valid,
    output logic                   fault_level,
    output logic [AW-1:0]          fault_va
);

    logic [AW-1:0]        root_q;
    logic [AW-1:0]        cur_root;
    logic [AW-1:0]        cur_pde;
    logic [AW-1:OFF_BITS] cur_vpn;
    logic [AW-1:0]        dir_addr;
    logic [AW-1:0]        tbl_addr;

    ptw_root_reg #(.AW(AW)) u_root (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (root_wr),
        .wdata (root_wdata),
        .q     (root_q)
    );

    ptw_addr_gen #(
        .AW         (AW),
        .OFF_BITS   (OFF_BITS),
        .DIR_BITS   (DIR_BITS),
        .ENTRY_LOG2 (ENTRY_LOG2)
    ) u_agen (
        .root     (cur_root),
        .pde      (cur_pde),
        .vpn      (cur_vpn),
        .dir_addr (dir_addr),
        .tbl_addr (tbl_addr)
    );

    ptw_fsm #(
        .AW          (AW),
        .OFF_BITS    (OFF_BITS),
        .PRESENT_BIT (PRESENT_BIT),
        .USER_BIT    (USER_BIT)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .va_in       (va),
        .root_q      (root_q),
        .root_wr     (root_wr),
        .root_wdata  (root_wdata),
        .dir_addr    (dir_addr),
        .tbl_addr    (tbl_addr),
        .rsp_valid   (mem_rsp_valid),
        .rsp_data    (mem_rsp_data),
        .cur_root    (cur_root),
        .cur_pde     (cur_pde),
        .cur_vpn     (cur_vpn),
        .busy        (busy),
        .req_valid   (mem_req_valid),
        .req_addr    (mem_req_addr),
        .done_valid  (done_valid),
        .done_vpn    (done_vpn),
        .done_pfn    (done_pfn),
        .done_flags  (done_flags),
        .done_user   (done_user),
        .fault_valid (fault_valid),
        .fault_level (fault_level),
        .fault_va    (fault_va)
    );

endmodule

// File: rtl/ptw_chk.sv
module ptw_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic mem_req_valid,
    input logic done_valid,
    input logic fault_valid
);

    // R11
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    // R11
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> busy);

    // R4
    done_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_valid && fault_valid));

    // R4
    end_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid || fault_valid) |=> !busy);

    // R8
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done_valid && !fault_valid));

endmodule

bind ptw_top ptw_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .done_valid    (done_valid),
    .fault_valid   (fault_valid)
);

// File: tb/tb_ptw_top.sv
`timescale 1ns/1ps
module tb_ptw_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        root_wr;
    logic [31:0] root_wdata;
    logic        start;
    logic [31:0] va;
    logic        busy;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        done_valid;
    logic [19:0] done_vpn;
    logic [19:0] done_pfn;
    logic [11:0] done_flags;
    logic        done_user;
    logic        fault_valid;
    logic        fault_level;
    logic [31:0] fault_va;

    always #2.5 clk = ~clk;

    ptw_top dut (.*);

    logic [31:0] mem [int unsigned];
    logic [31:0] log_addr [0:3];
    int          log_cnt;
    int          n_chk;
    int          n_err;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Memory responder: at least one cycle of latency
    initial begin
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (rst_n && mem_req_valid) begin
                automatic logic [31:0] a = mem_req_addr;
                if (log_cnt < 4) log_addr[log_cnt] = a;
                log_cnt++;
                repeat (1 + $urandom_range(3)) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = rd(a);
            end
        end
    end

    task automatic set_root(input logic [31:0] r);
        root_wr    = 1'b1;
        root_wdata = r;
        @(negedge clk);
        root_wr    = 1'b0;
    endtask

    // One walk: expected results come from the bench's own table model
    task automatic walk(input logic [31:0] v, input logic [31:0] r,
                        input bit wr_now, input bit poke, input string tag);
        logic [31:0] a1, a2, pde, pte;
        int kind;
        int t;
        int cnt_end;
        a1  = {r[31:12], 12'h0} + {20'h0, v[31:22], 2'b00};
        pde = rd(a1);
        a2  = {pde[31:12], 12'h0} + {20'h0, v[21:12], 2'b00};
        pte = rd(a2);
        kind = !pde[0] ? 1 : (!pte[0] ? 2 : 0);
        log_cnt = 0;
        start = 1'b1;
        va    = v;
        if (wr_now) begin
            root_wr    = 1'b1;
            root_wdata = r;
        end
        @(negedge clk);
        start   = 1'b0;
        root_wr = 1'b0;
        if (poke) begin
            start      = 1'b1;
            va         = ~v;
            root_wr    = 1'b1;
            root_wdata = 32'hDEAD0000;
            @(negedge clk);
            start   = 1'b0;
            root_wr = 1'b0;
        end
        t = 0;
        while (!done_valid && !fault_valid && t < 60) begin
            @(negedge clk);
            t++;
        end
        chk(log_addr[0] == a1, "R2", {tag, " first read address"}, log_addr[0], a1);
        if (kind == 0) begin
            chk(done_valid && !fault_valid, "R4", {tag, " done"}, {30'h0, done_valid, fault_valid}, 32'h2);
            chk(done_pfn == pte[31:12], "R4", {tag, " pfn"}, {12'h0, done_pfn}, {12'h0, pte[31:12]});
            chk(done_flags == pte[11:0], "R4", {tag, " flags"}, {20'h0, done_flags}, {20'h0, pte[11:0]});
            chk(done_vpn == v[31:12], "R4", {tag, " vpn"}, {12'h0, done_vpn}, {12'h0, v[31:12]});
            chk(done_user == (pde[2] & pte[2]), "R7", {tag, " user"}, {31'h0, done_user}, {31'h0, pde[2] & pte[2]});
        end else begin
            chk(fault_valid && !done_valid, kind == 1 ? "R5" : "R6", {tag, " fault"},
                {30'h0, done_valid, fault_valid}, 32'h1);
            chk(fault_level == (kind == 2), kind == 1 ? "R5" : "R6", {tag, " level"},
                {31'h0, fault_level}, {31'h0, kind == 2});
            chk(fault_va == v, kind == 1 ? "R5" : "R6", {tag, " fault va"}, fault_va, v);
        end
        if (kind != 1) begin
            chk(log_addr[1] == a2, "R3", {tag, " second read address"}, log_addr[1], a2);
            chk(log_cnt == 2, "R3", {tag, " read count"}, log_cnt, 2);
        end else begin
            chk(log_cnt == 1, "R5", {tag, " read count"}, log_cnt, 1);
        end
        cnt_end = log_cnt;
        @(negedge clk);
        chk(!busy, "R11", {tag, " idle after end"}, {31'h0, busy}, 32'h0);
        if (poke) begin
            repeat (4) @(negedge clk);
            chk(log_cnt == cnt_end && !busy, "R8", {tag, " no walk from ignored start"}, log_cnt, cnt_end);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        n_chk = 0;
        n_err = 0;
        log_cnt = 0;
        rst_n = 1'b0;
        root_wr = 1'b0;
        root_wdata = '0;
        start = 1'b0;
        va = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req_valid && !done_valid && !fault_valid, "R1", "in reset",
            {28'h0, busy, mem_req_valid, done_valid, fault_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_req_valid && !done_valid && !fault_valid, "R1", "after reset",
            {28'h0, busy, mem_req_valid, done_valid, fault_valid}, 32'h0);

        mem[32'h12345000] = 32'h12344007;
        mem[32'h12344800] = 32'h72445005;
        mem[32'h12345FFC] = 32'h12345003;
        mem[32'h12345008] = 32'h12346001;
        mem[32'h1234600C] = 32'h00000000;

        // R9: root written in the same cycle as the start
        walk(32'h00200000, 32'h12345000, 1'b1, 1'b0, "R9 same-cycle root");
        chk(done_pfn == 20'h72445, "R4", "directed frame", {12'h0, done_pfn}, 32'h72445);
        // R10: self-referencing directory entry
        walk(32'hFFFFF000, 32'h12345000, 1'b0, 1'b0, "R10 self-ref");
        chk(done_pfn == 20'h12345 && log_addr[1] == 32'h12345FFC, "R10", "self-ref frame",
            {12'h0, done_pfn}, 32'h12345);
        // R5: absent directory entry
        walk(32'h00400000, 32'h12345000, 1'b0, 1'b0, "R5 dir absent");
        // R6: absent leaf entry
        walk(32'h00803000, 32'h12345000, 1'b0, 1'b0, "R6 leaf absent");
        // R8 and R9: start and root write while busy
        walk(32'h00200000, 32'h12345000, 1'b0, 1'b1, "R8 busy start");
        set_root(32'h12345000);
        walk(32'h00200000, 32'h12345000, 1'b0, 1'b0, "R9 root restored");

        // Random tables and addresses
        for (int i = 0; i < 40; i++) begin
            automatic logic [31:0] r  = {$urandom_range(32'h10000, 32'h1FFFF), 12'h0} | $urandom_range(0, 32'hFFF);
            automatic logic [31:0] v  = $urandom;
            automatic logic [31:0] a1 = {r[31:12], 12'h0} + {20'h0, v[31:22], 2'b00};
            automatic logic [31:0] pde = {$urandom_range(32'h20000, 32'h2FFFF), 12'h0} |
                                         ($urandom & 32'hFFE) | {31'h0, ($urandom_range(7) != 0)};
            automatic logic [31:0] a2 = {pde[31:12], 12'h0} + {20'h0, v[21:12], 2'b00};
            mem[a1] = pde;
            mem[a2] = ($urandom & 32'hFFFFFFFE) | {31'h0, ($urandom_range(7) != 0)};
            walk(v, r, 1'b1, (i % 8) == 3, "random R4 R7");
            if ((i % 8) == 3) set_root(r);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule